// File: doc/BRIEF.md
# Programmable Horizontal Blanking Generator

This block produces the horizontal blanking signal of an image-sensor timing generator. It runs on the pixel clock. A pixel counter restarts on every horizontal sync pulse. The blanking output flips each time the count reaches one of up to six programmable toggle points. Two toggle points give a plain blanking interval. The other four carve extra pulse groups out of that interval.

Toggle points come in two sets per register bank, one for even lines and one for odd lines. An alternation flag in each bank decides whether the odd set is used at all. Several banks are held side by side, one per vertical timing sequence, and a select input names the bank for the next line. The bank choice and the even/odd choice are fixed at the line boundary. While blanking is active, the block forces three groups of horizontal clock outputs to polarities programmed in the bank. These groups are the first phase group, the second phase group and the HL clock. Outside blanking they pass the incoming clock phase through.

Top module: `hblank_gen`

## Requirements
- R1: `pixCnt` is 0 in the cycle after `hdIn` is sampled high. It then rises by one per pixel clock and holds at 8191 (all ones) instead of wrapping.
- R2: `hblank` is registered and lines up with `pixCnt`. Its value for a count c is the parity of the number of distinct enabled toggle points of the line's set that are less than or equal to c. A toggle point at c therefore takes effect in the cycle where `pixCnt` equals c.
- R3: Every line starts with blanking inactive, even if the previous line ended with blanking active. The first toggle point reached begins blanking.
- R4: A toggle point equal to 8191 is disabled and never flips the output.
- R5: Two or more enabled toggle points with the same value count as a single toggle.
- R6: `lineOdd` inverts on every HD pulse and clears to 0 whenever `frameRst` is sampled high. When both arrive in the same cycle, the result is 0. A line uses the odd toggle set only if the parity it started with is 1 and the bank's alternation flag is 1. Otherwise it uses the even set. A mid-line `frameRst` does not change the set of the current line.
- R7: The bank used for a line is the value of `seqSel` sampled with `hdIn`. Changes of `seqSel` during the line affect neither `hblank` nor the masked clock levels.
- R8: The bank's polarity field `maskPol[3b+2:3b]` holds bit 0 for the first phase group, bit 1 for the second group and bit 2 for HL. While `hblank` is 1, every `h1Out` bit equals bit 0, every `h2Out` bit equals bit 1, and `hlOut` equals bit 2. While `hblank` is 0, `h1Out` bits and `hlOut` equal `hClkPhase`, and `h2Out` bits equal its complement.
- R9: While `rstN` is low, `pixCnt` is 0, `hblank` is 0 and `lineOdd` is 0.
- R10: Toggle point i of bank b lives at bits `[(6b+i)*13 +: 13]` of `togEven`/`togOdd`. The bank's alternation flag is `altEn[b]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hdIn | input | 1 | Horizontal sync, one cycle high per line |
| frameRst | input | 1 | Clears the line parity flag |
| seqSel | input | 2 | Vertical sequence bank for the next line |
| hClkPhase | input | 1 | Incoming horizontal clock phase |
| togEven | input | 312 | Even-line toggle points, 4 banks x 6 x 13 bits |
| togOdd | input | 312 | Odd-line toggle points, same layout |
| maskPol | input | 12 | Mask polarities, 3 bits per bank |
| altEn | input | 4 | Even/odd alternation flag per bank |
| pixCnt | output | 13 | Pixel count within the line |
| lineOdd | output | 1 | Line parity flag |
| hblank | output | 1 | Horizontal blanking |
| h1Out | output | 4 | First phase clock group |
| h2Out | output | 4 | Second phase clock group |
| hlOut | output | 1 | HL clock |

## Verification
The hardest situation to reach is a line whose toggle set was chosen from state that has since moved on. Examples are a parity flag cleared mid-line, a select input changed after the boundary, or an odd toggle count leaving blanking high into the next boundary. The bench drives a fresh random `seqSel` every pixel clock and pulses `frameRst` in the middle of chosen lines. It also gives each bank a different pattern and polarity, so a set or bank change at the wrong moment alters the checked waveform. Random toggle sets mix disabled values, duplicates and a point at count 0. A long line drives the counter into saturation.

// File: rtl/hblank_pkg.sv
package hblank_pkg;
  // strobes from control to datapath, valid for the count being entered
  typedef struct packed {
    logic lineStart;   // HD sampled this cycle
    logic useOddNext;  // odd toggle set applies to the next count
  } hbStrb_t;
endpackage

// File: rtl/hblank_ctrl.sv
module hblank_ctrl
  import hblank_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int N_BANK = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdIn,
  input  logic              frameRst,
  input  logic [BANK_W-1:0] seqSel,
  input  logic [N_BANK-1:0] altEn,
  output hbStrb_t           strb,
  output logic [CNT_W-1:0]  cntNext,
  output logic [CNT_W-1:0]  pixCnt,
  output logic              lineOdd,
  output logic [BANK_W-1:0] bankQ,
  output logic [BANK_W-1:0] bankNext
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ;
  logic             oddQ;
  logic             oddNext;
  logic             setOddQ;
  logic             setOddNext;

  always_comb begin
    if (hdIn)                cntNext = '0;
    else if (cntQ == CNT_MAX) cntNext = cntQ;
    else                     cntNext = cntQ + 1'b1;

    if (frameRst)  oddNext = 1'b0;
    else if (hdIn) oddNext = ~oddQ;
    else           oddNext = oddQ;

    bankNext   = hdIn ? seqSel : bankQ;
    setOddNext = hdIn ? (oddNext & altEn[bankNext]) : setOddQ;

    strb.lineStart  = hdIn;
    strb.useOddNext = setOddNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      oddQ    <= 1'b0;
      setOddQ <= 1'b0;
      bankQ   <= '0;
    end else begin
      cntQ    <= cntNext;
      oddQ    <= oddNext;
      setOddQ <= setOddNext;
      bankQ   <= bankNext;
    end
  end

  assign pixCnt  = cntQ;
  assign lineOdd = oddQ;
endmodule

// File: rtl/hblank_tog_match.sv
module hblank_tog_match #(
  parameter int CNT_W = 13,
  parameter int N_TOG = 6
) (
  input  logic [N_TOG*CNT_W-1:0] togSet,
  input  logic [CNT_W-1:0]       cnt,
  output logic                   hit
);
  localparam logic [CNT_W-1:0] OFF_VAL = {CNT_W{1'b1}};

  logic [N_TOG-1:0] hitVec;

  genvar gi;
  generate
    for (gi = 0; gi < N_TOG; gi++) begin : g_cmp
      logic [CNT_W-1:0] pt;
      assign pt         = togSet[gi*CNT_W +: CNT_W];
      assign hitVec[gi] = (pt != OFF_VAL) && (pt == cnt);
    end
  endgenerate

  // equal points merge into one toggle
  assign hit = |hitVec;
endmodule

// File: rtl/hblank_datapath.sv
module hblank_datapath
  import hblank_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int N_TOG  = 6,
  parameter int N_BANK = 4,
  parameter int BANK_W = 2,
  parameter int N_PH   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  hbStrb_t                       strb,
  input  logic [CNT_W-1:0]              cntNext,
  input  logic [BANK_W-1:0]             bankNext,
  input  logic [BANK_W-1:0]             bankQ,
  input  logic [N_BANK*N_TOG*CNT_W-1:0] togEven,
  input  logic [N_BANK*N_TOG*CNT_W-1:0] togOdd,
  input  logic [N_BANK*3-1:0]           maskPol,
  input  logic                          hClkPhase,
  output logic                          hblank,
  output logic [N_PH-1:0]               h1Out,
  output logic [N_PH-1:0]               h2Out,
  output logic                          hlOut
);
  localparam int SET_W = N_TOG * CNT_W;

  logic [SET_W-1:0] setNext;
  logic             hit;
  logic             blankQ;
  logic [2:0]       pol;

  always_comb begin
    if (strb.useOddNext) setNext = togOdd[int'(bankNext)*SET_W +: SET_W];
    else                 setNext = togEven[int'(bankNext)*SET_W +: SET_W];
  end

  hblank_tog_match #(.CNT_W(CNT_W), .N_TOG(N_TOG)) u_match (
    .togSet (setNext),
    .cnt    (cntNext),
    .hit    (hit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               blankQ <= 1'b0;
    else if (strb.lineStart) blankQ <= hit;
    else                     blankQ <= blankQ ^ hit;
  end

  always_comb begin
    pol = maskPol[int'(bankQ)*3 +: 3];
    if (blankQ) begin
      h1Out = {N_PH{pol[0]}};
      h2Out = {N_PH{pol[1]}};
      hlOut = pol[2];
    end else begin
      h1Out = {N_PH{hClkPhase}};
      h2Out = {N_PH{~hClkPhase}};
      hlOut = hClkPhase;
    end
  end

  assign hblank = blankQ;
endmodule

// File: rtl/hblank_gen.sv
module hblank_gen
  import hblank_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int N_TOG  = 6,
  parameter int N_BANK = 4,
  parameter int N_PH   = 4,
  localparam int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hdIn,
  input  logic                          frameRst,
  input  logic [BANK_W-1:0]             seqSel,
  input  logic                          hClkPhase,
  input  logic [N_BANK*N_TOG*CNT_W-1:0] togEven,
  input  logic [N_BANK*N_TOG*CNT_W-1:0] togOdd,
  input  logic [N_BANK*3-1:0]           maskPol,
  input  logic [N_BANK-1:0]             altEn,
  output logic [CNT_W-1:0]              pixCnt,
  output logic                          lineOdd,
  output logic                          hblank,
  output logic [N_PH-1:0]               h1Out,
  output logic [N_PH-1:0]               h2Out,
  output logic                          hlOut
);
  hbStrb_t           strb;
  logic [CNT_W-1:0]  cntNext;
  logic [BANK_W-1:0] bankQ;
  logic [BANK_W-1:0] bankNext;

  hblank_ctrl #(.CNT_W(CNT_W), .N_BANK(N_BANK), .BANK_W(BANK_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hdIn     (hdIn),
    .frameRst (frameRst),
    .seqSel   (seqSel),
    .altEn    (altEn),
    .strb     (strb),
    .cntNext  (cntNext),
    .pixCnt   (pixCnt),
    .lineOdd  (lineOdd),
    .bankQ    (bankQ),
    .bankNext (bankNext)
  );

  hblank_datapath #(
    .CNT_W(CNT_W), .N_TOG(N_TOG), .N_BANK(N_BANK), .BANK_W(BANK_W), .N_PH(N_PH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cntNext   (cntNext),
    .bankNext  (bankNext),
    .bankQ     (bankQ),
    .togEven   (togEven),
    .togOdd    (togOdd),
    .maskPol   (maskPol),
    .hClkPhase (hClkPhase),
    .hblank    (hblank),
    .h1Out     (h1Out),
    .h2Out     (h2Out),
    .hlOut     (hlOut)
  );
endmodule

// File: rtl/hblank_chk.sv
module hblank_chk #(
  parameter int CNT_W  = 13,
  parameter int N_PH   = 4,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              hdIn,
  input logic              frameRst,
  input logic              hClkPhase,
  input logic [CNT_W-1:0]  pixCnt,
  input logic              lineOdd,
  input logic              hblank,
  input logic [N_PH-1:0]   h1Out,
  input logic [N_PH-1:0]   h2Out,
  input logic [BANK_W-1:0] bankQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R1
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdIn |=> (pixCnt == '0));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hdIn && pixCnt != CNT_MAX) |=> (pixCnt == $past(pixCnt) + 1'b1));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hdIn && pixCnt == CNT_MAX) |=> $stable(pixCnt));

  // R6
  parity_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdIn && !frameRst) |=> (lineOdd != $past(lineOdd)));

  // R6
  parity_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameRst |=> !lineOdd);

  // R6
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hdIn && !frameRst) |=> $stable(lineOdd));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hdIn |=> $stable(bankQ));

  // R8
  pass_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hblank |-> (h1Out == {N_PH{hClkPhase}} && h2Out == {N_PH{~hClkPhase}}));

  // R8
  group_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    hblank |-> ($countones(h1Out) == 0 || $countones(h1Out) == N_PH));
endmodule

bind hblank_gen hblank_chk #(.CNT_W(CNT_W), .N_PH(N_PH), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hdIn      (hdIn),
  .frameRst  (frameRst),
  .hClkPhase (hClkPhase),
  .pixCnt    (pixCnt),
  .lineOdd   (lineOdd),
  .hblank    (hblank),
  .h1Out     (h1Out),
  .h2Out     (h2Out),
  .bankQ     (bankQ)
);

// File: tb/tb_hblank_gen.sv
module tb_hblank_gen;
  localparam int CW = 13;
  localparam int NT = 6;
  localparam int NB = 4;
  localparam int NP = 4;
  localparam int OFF = 8191;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdIn = 1'b0;
  logic frameRst = 1'b0;
  logic [1:0] seqSel = '0;
  logic hClkPhase = 1'b0;
  logic [NB*NT*CW-1:0] togEvenV;
  logic [NB*NT*CW-1:0] togOddV;
  logic [NB*3-1:0] maskPolV;
  logic [NB-1:0] altEnV;
  logic [CW-1:0] pixCnt;
  logic lineOdd, hblank, hlOut;
  logic [NP-1:0] h1Out, h2Out;

  int togE [NB][NT];
  int togO [NB][NT];
  logic [2:0] pol [NB];
  logic alt [NB];

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  bit expOdd = 1'b0;
  bit frPending = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < NT; i++) begin
        togEvenV[(b*NT+i)*CW +: CW] = CW'(togE[b][i]);
        togOddV[(b*NT+i)*CW +: CW]  = CW'(togO[b][i]);
      end
      maskPolV[b*3 +: 3] = pol[b];
      altEnV[b] = alt[b];
    end
  end

  hblank_gen dut (
    .clk(clk), .rstN(rstN), .hdIn(hdIn), .frameRst(frameRst), .seqSel(seqSel),
    .hClkPhase(hClkPhase), .togEven(togEvenV), .togOdd(togOddV),
    .maskPol(maskPolV), .altEn(altEnV), .pixCnt(pixCnt), .lineOdd(lineOdd),
    .hblank(hblank), .h1Out(h1Out), .h2Out(h2Out), .hlOut(hlOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected blanking level at count c for a toggle set
  function automatic bit expBlank(input int c, input int pts [NT]);
    int n = 0;
    for (int i = 0; i < NT; i++) begin
      bit dup = 1'b0;
      for (int j = 0; j < i; j++) if (pts[j] == pts[i]) dup = 1'b1;
      if (pts[i] != OFF && pts[i] <= c && !dup) n++;
    end
    return n[0];
  endfunction

  task automatic setBank(input int b, input int e0, input int e1, input int e2,
                         input int e3, input int e4, input int e5);
    togE[b][0] = e0; togE[b][1] = e1; togE[b][2] = e2;
    togE[b][3] = e3; togE[b][4] = e4; togE[b][5] = e5;
  endtask

  task automatic randBank(input int b, input int span);
    for (int i = 0; i < NT; i++) begin
      int r = $urandom_range(0, 9);
      togE[b][i] = (r == 0) ? OFF : $urandom_range(0, span);
      r = $urandom_range(0, 9);
      togO[b][i] = (r == 0) ? OFF : $urandom_range(0, span);
    end
    if ($urandom_range(0, 3) == 0) togE[b][3] = togE[b][1];  // duplicate, R5
    pol[b] = 3'($urandom);
    alt[b] = 1'($urandom);
  endtask

  task automatic runLine(input int len, input int sel, input bit frAtHd,
                         input int midFr, input string tag);
    int pts [NT];
    logic [2:0] lp;
    @(negedge clk);
    if (frPending) expOdd = 1'b0;
    frPending = 1'b0;
    hdIn = 1'b1; seqSel = 2'(sel); frameRst = frAtHd;
    expOdd = frAtHd ? 1'b0 : ~expOdd;
    for (int i = 0; i < NT; i++)
      pts[i] = (alt[sel] && expOdd) ? togO[sel][i] : togE[sel][i];
    lp = pol[sel];
    for (int c = 0; c < len; c++) begin
      int ec;
      bit eb;
      @(negedge clk);
      hdIn = 1'b0; frameRst = 1'b0;
      if (frPending) expOdd = 1'b0;
      frPending = 1'b0;
      seqSel = 2'($urandom_range(0, 3));   // ignored mid-line, R7
      hClkPhase = 1'($urandom);
      #1;
      ec = (c > OFF) ? OFF : c;
      eb = expBlank(ec, pts);
      check(pixCnt == CW'(ec), "R1 count", int'(pixCnt), ec);
      check(hblank == eb, tag, int'(hblank), int'(eb));
      check(lineOdd == expOdd, "R6 parity", int'(lineOdd), int'(expOdd));
      if (eb) begin
        check(h1Out == {NP{lp[0]}} && h2Out == {NP{lp[1]}} && hlOut == lp[2],
              "R8 masked", int'({hlOut, h2Out, h1Out}), int'({lp[2], {NP{lp[1]}}, {NP{lp[0]}}}));
      end else begin
        check(h1Out == {NP{hClkPhase}} && h2Out == {NP{~hClkPhase}} && hlOut == hClkPhase,
              "R8 pass", int'({hlOut, h2Out, h1Out}),
              int'({hClkPhase, {NP{~hClkPhase}}, {NP{hClkPhase}}}));
      end
      if (c == midFr) begin
        frameRst = 1'b1;
        frPending = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < NT; i++) begin togE[b][i] = OFF; togO[b][i] = OFF; end
      pol[b] = 3'b000; alt[b] = 1'b0;
    end
    repeat (3) @(negedge clk);
    hClkPhase = 1'b1; #1;
    // R9 reset state
    check(pixCnt == 0, "R9 count", int'(pixCnt), 0);
    check(hblank == 0, "R9 blank", int'(hblank), 0);
    check(lineOdd == 0, "R9 parity", int'(lineOdd), 0);
    check(h1Out == '1 && h2Out == '0, "R9 clocks", int'({h2Out, h1Out}), int'({4'h0, 4'hF}));
    @(negedge clk); rstN = 1'b1;

    // R2 basic window and six-point pattern (R10 layout)
    setBank(0, 5, 20, OFF, OFF, OFF, OFF); pol[0] = 3'b101;
    setBank(1, 3, 30, 8, 12, 16, 20); pol[1] = 3'b010;
    runLine(40, 0, 1'b1, -1, "R2 basic");
    runLine(40, 1, 1'b0, -1, "R2 six-point");
    // R3 odd toggle count leaves blank high; next line restarts low
    setBank(2, 10, OFF, OFF, OFF, OFF, OFF); pol[2] = 3'b011;
    runLine(25, 2, 1'b0, -1, "R3 open end");
    setBank(0, 30, 35, OFF, OFF, OFF, OFF);
    runLine(40, 0, 1'b0, -1, "R3 line start");
    // R4 disabled points, R5 duplicates, toggle at count 0
    setBank(3, OFF, 7, OFF, 7, 15, 0); pol[3] = 3'b110;
    runLine(30, 3, 1'b0, -1, "R5 dup and R4 off");
    // R6 alternation: odd set differs from even set
    alt[1] = 1'b1;
    for (int i = 0; i < NT; i++) togO[1][i] = OFF;
    togO[1][0] = 2; togO[1][1] = 4;
    runLine(30, 1, 1'b1, -1, "R6 even line");
    runLine(30, 1, 1'b0, 10, "R6 odd line mid reset");
    runLine(30, 1, 1'b0, -1, "R6 after reset");
    alt[1] = 1'b0;
    runLine(30, 1, 1'b0, -1, "R6 alt off");
    // R1 saturation
    setBank(0, 3, 8190, OFF, OFF, OFF, OFF);
    runLine(8200, 0, 1'b0, -1, "R1 saturate");

    // random lines, R7 select noise throughout
    for (int n = 0; n < 120; n++) begin
      int len = $urandom_range(12, 90);
      int sel = $urandom_range(0, 3);
      int mid = ($urandom_range(0, 5) == 0) ? $urandom_range(1, len - 2) : -1;
      randBank(sel, len + 4);
      runLine(len, sel, 1'($urandom_range(0, 7) == 0), mid, "R7 R2 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule